// File: doc/BRIEF.md
# Linked Descriptor DMA Engine

This engine moves data for up to 128 logical channels, one channel at a time. Every channel owns a three-word control record in a small local RAM. A trigger names a channel. The engine fetches that channel's record and moves data units over a valid/ready memory port. Each unit is one read at the source address followed by one write of the same data at the destination address. After the run it stores the updated count and addresses back into the record. It then signals completion and may go on to a follow-up channel without a new trigger.

Three run styles are supported. A single run moves one unit per trigger, a successive run moves every remaining unit, and a block run moves one block per trigger. The source and destination addresses each have their own stepping control. Software loads and inspects records through a configuration port while the engine is idle.

The controller is one state machine with these states:
- S_IDLE: waits for a trigger.
- S_LOAD: reads the three record words.
- S_DECODE: checks the mode and sets up the counters.
- S_READ and S_WRITE: the two memory phases of a unit.
- S_STEP: counts the unit and steps the addresses.
- S_CLOSE: block bookkeeping and address reload.
- S_WBACK: writes the three words back.
- S_FINISH: completion, interrupt and follow-up.
- S_FAULT: reports a bad mode.

The transitions are:
- S_IDLE to S_LOAD on an accepted trigger.
- S_LOAD to S_DECODE after the third word.
- S_DECODE to S_FAULT on the reserved mode, to S_CLOSE when there is no unit to move, and to S_READ otherwise.
- S_READ to S_WRITE, and S_WRITE to S_STEP, each on mem_ready.
- S_STEP back to S_READ while units remain, and to S_CLOSE after the last one.
- S_CLOSE to S_WBACK.
- S_WBACK to S_FINISH after the third word.
- S_FINISH to S_LOAD when a follow-up channel is started, and to S_IDLE otherwise.
- S_FAULT to S_IDLE.

Top module: `dma_link_engine`

## Requirements
- R1: After reset, trig_ready is 1 and mem_valid, irq and err are all 0.
- R2: A record whose word 3 bits 31:30 equal 11 makes err pulse for one cycle, with evt_chan set to that channel. No memory access is made and the record is left unchanged.
- R3: Each unit is a read (mem_write=0) at the source address followed by a write (mem_write=1) at the destination address. The write carries the data that was read. mem_half equals word 2 bit 30, and mem_valid holds with a stable address until mem_ready.
- R4: The address controls are word 2 bits 29:28 for the source and word 3 bits 29:28 for the destination. Codes 11 and 10 step up, 01 steps down and 00 holds the address. The step is 1 for byte units and 2 for half-word units.
- R5: Successive mode (word 3 bits 31:30 = 01) moves the whole 24-bit count on one trigger. The count has word 1 bits 23:8 as its high part and bits 7:0 as its low part.
- R6: Single mode (00) moves one unit per trigger. When a trigger ends without finishing the channel, the decremented count and the current addresses are written back, so the next trigger resumes from that point.
- R7: Block mode (10) moves word 1 bits 7:0 units per trigger and decrements the block count in bits 23:8. At each block end, address code 10 restores the address held at the start of the trigger, and code 11 keeps the advanced address.
- R8: irq pulses for one cycle, with evt_chan set to the channel, only when the channel's count reaches zero and word 2 bit 31 is 1.
- R9: When a channel finishes and word 1 bit 31 is 1, the channel numbered in bits 30:24 starts without a trigger. A channel that has not finished starts no follow-up.
- R10: While the engine is busy, trig_ready is 0 and trig_valid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trig_valid | input | 1 | Start request |
| trig_chan | input | 7 | Channel to start |
| trig_ready | output | 1 | Engine idle, trigger accepted |
| cfg_we | input | 1 | Record write strobe |
| cfg_chan | input | 7 | Record channel for the config port |
| cfg_word | input | 2 | Record word index, 0 to 2 |
| cfg_wdata | input | 32 | Record write data |
| cfg_rdata | output | 32 | Record read data (combinational) |
| mem_valid | output | 1 | Memory request |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_half | output | 1 | Half-word unit when 1 |
| mem_addr | output | 28 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Memory accepts or returns data |
| mem_rdata | input | 16 | Read data, valid with mem_ready on a read |
| irq | output | 1 | Completion pulse |
| err | output | 1 | Bad-mode pulse |
| evt_chan | output | 7 | Channel for irq or err |

## Verification
The assertions assume two things about the memory port. mem_ready is meaningful only while mem_valid is high, and mem_rdata is valid in the cycle that mem_ready completes a read. They also assume the configuration port writes records only while trig_ready is high, because the engine's write-back shares the RAM write port. The stimulus writes every record before its trigger, waits for trig_ready before the next record access, and uses a memory model that raises mem_ready only against a pending request, after zero to two stall cycles. The single trigger sent during a busy period is one cycle long, so it ends well before the engine returns to idle.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_LOAD, S_DECODE, S_READ, S_WRITE,
        S_STEP, S_CLOSE, S_WBACK, S_FINISH, S_FAULT
    } dma_state_t;

    localparam logic [1:0] RUN_SINGLE = 2'b00;
    localparam logic [1:0] RUN_SUCC   = 2'b01;
    localparam logic [1:0] RUN_BLOCK  = 2'b10;
    localparam logic [1:0] RUN_RSVD   = 2'b11;

    localparam logic [1:0] ADR_RELOAD = 2'b10;

endpackage

// File: rtl/dma_desc_ram.sv
module dma_desc_ram #(
    parameter int DEPTH = 384,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [31:0]   wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [31:0]   rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [31:0]   rdata_b
);
    logic [31:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
    end

    assign rdata_a = cells[ridx_a];
    assign rdata_b = cells[ridx_b];
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 28
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    ctl,
    input  logic          half,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step;

    always_comb begin
        step = half ? AW'(2) : AW'(1);
        if (ctl[1])      nxt = addr + step;
        else if (ctl[0]) nxt = addr - step;
        else             nxt = addr;
    end
endmodule

// File: rtl/dma_link_engine.sv
module dma_link_engine
    import dma_pkg::*;
#(
    parameter int CHANS = 128,
    parameter int AW    = 28,
    parameter int DW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trig_valid,
    input  logic [$clog2(CHANS)-1:0]   trig_chan,
    output logic                       trig_ready,
    input  logic                       cfg_we,
    input  logic [$clog2(CHANS)-1:0]   cfg_chan,
    input  logic [1:0]                 cfg_word,
    input  logic [31:0]                cfg_wdata,
    output logic [31:0]                cfg_rdata,
    output logic                       mem_valid,
    output logic                       mem_write,
    output logic                       mem_half,
    output logic [AW-1:0]              mem_addr,
    output logic [DW-1:0]              mem_wdata,
    input  logic                       mem_ready,
    input  logic [DW-1:0]              mem_rdata,
    output logic                       irq,
    output logic                       err,
    output logic [$clog2(CHANS)-1:0]   evt_chan
);
    localparam int CHW   = $clog2(CHANS);
    localparam int DEPTH = CHANS * 3;
    localparam int RAW   = $clog2(DEPTH);

    dma_state_t    st, st_nx;
    logic [CHW-1:0] chan;
    logic [1:0]    widx;
    logic [31:0]   w1, w2, w3;
    logic [23:0]   cnt, run, run_init;
    logic [15:0]   blocks;
    logic [AW-1:0] src, dst, src0, dst0, src_nx, dst_nx;
    logic [DW-1:0] data;
    logic [1:0]    mode;
    logic          is_block, complete, fsm_we;
    logic [31:0]   rd_word, wb_word;
    logic [RAW-1:0] fsm_idx, cfg_idx;

    assign mode     = w3[31:30];
    assign is_block = (mode == RUN_BLOCK);
    assign complete = is_block ? (blocks == 16'd0) : (cnt == 24'd0);
    assign fsm_idx  = RAW'(chan) * RAW'(3) + RAW'(widx);
    assign cfg_idx  = RAW'(cfg_chan) * RAW'(3) + RAW'(cfg_word);

    dma_desc_ram #(.DEPTH(DEPTH), .IW(RAW)) u_ram (
        .clk    (clk),
        .we     (fsm_we | cfg_we),
        .widx   (fsm_we ? fsm_idx : cfg_idx),
        .wdata  (fsm_we ? wb_word : cfg_wdata),
        .ridx_a (fsm_idx),
        .rdata_a(rd_word),
        .ridx_b (cfg_idx),
        .rdata_b(cfg_rdata)
    );

    dma_addr_step #(.AW(AW)) u_src_step (
        .addr(src), .ctl(w2[29:28]), .half(w2[30]), .nxt(src_nx)
    );
    dma_addr_step #(.AW(AW)) u_dst_step (
        .addr(dst), .ctl(w3[29:28]), .half(w2[30]), .nxt(dst_nx)
    );

    always_comb begin
        unique case (mode)
            RUN_SINGLE: run_init = (w1[23:0] != 24'd0) ? 24'd1 : 24'd0;
            RUN_SUCC:   run_init = w1[23:0];
            RUN_BLOCK:  run_init = (w1[23:8] != 16'd0) ? {16'd0, w1[7:0]} : 24'd0;
            default:    run_init = 24'd0;
        endcase
    end

    always_comb begin
        unique case (widx)
            2'd0:    wb_word = {w1[31:24], is_block ? {blocks, w1[7:0]} : cnt};
            2'd1:    wb_word = {w2[31:28], src};
            default: wb_word = {w3[31:28], dst};
        endcase
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (trig_valid) st_nx = S_LOAD;
            S_LOAD:   if (widx == 2'd2) st_nx = S_DECODE;
            S_DECODE: if (mode == RUN_RSVD) st_nx = S_FAULT;
                      else if (run_init == 24'd0) st_nx = S_CLOSE;
                      else st_nx = S_READ;
            S_READ:   if (mem_ready) st_nx = S_WRITE;
            S_WRITE:  if (mem_ready) st_nx = S_STEP;
            S_STEP:   st_nx = (run == 24'd1) ? S_CLOSE : S_READ;
            S_CLOSE:  st_nx = S_WBACK;
            S_WBACK:  if (widx == 2'd2) st_nx = S_FINISH;
            S_FINISH: st_nx = (complete && w1[31]) ? S_LOAD : S_IDLE;
            S_FAULT:  st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan <= '0; widx <= '0; w1 <= '0; w2 <= '0; w3 <= '0;
            cnt <= '0; run <= '0; blocks <= '0; data <= '0;
            src <= '0; dst <= '0; src0 <= '0; dst0 <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (trig_valid) begin
                    chan <= trig_chan;
                    widx <= 2'd0;
                end
                S_LOAD: begin
                    if (widx == 2'd0) w1 <= rd_word;
                    if (widx == 2'd1) w2 <= rd_word;
                    if (widx == 2'd2) w3 <= rd_word;
                    widx <= (widx == 2'd2) ? 2'd0 : widx + 2'd1;
                end
                S_DECODE: begin
                    cnt    <= w1[23:0];
                    blocks <= w1[23:8];
                    run    <= run_init;
                    src    <= w2[AW-1:0];
                    dst    <= w3[AW-1:0];
                    src0   <= w2[AW-1:0];
                    dst0   <= w3[AW-1:0];
                end
                S_READ: if (mem_ready) data <= mem_rdata;
                S_STEP: begin
                    run <= run - 24'd1;
                    if (!is_block) cnt <= cnt - 24'd1;
                    src <= src_nx;
                    dst <= dst_nx;
                end
                S_CLOSE: if (is_block) begin
                    if (blocks != 16'd0) blocks <= blocks - 16'd1;
                    if (w2[29:28] == ADR_RELOAD) src <= src0;
                    if (w3[29:28] == ADR_RELOAD) dst <= dst0;
                end
                S_WBACK: widx <= (widx == 2'd2) ? 2'd0 : widx + 2'd1;
                S_FINISH: if (complete && w1[31]) begin
                    chan <= w1[24 +: CHW];
                    widx <= 2'd0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        trig_ready = (st == S_IDLE);
        mem_valid  = (st == S_READ) || (st == S_WRITE);
        mem_write  = (st == S_WRITE);
        mem_addr   = (st == S_WRITE) ? dst : src;
        mem_half   = w2[30];
        mem_wdata  = data;
        fsm_we     = (st == S_WBACK);
        irq        = (st == S_FINISH) && complete && w2[31];
        err        = (st == S_FAULT);
        evt_chan   = chan;
    end
endmodule

// File: rtl/dma_link_chk.sv
module dma_link_chk #(
    parameter int AW = 28
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig_ready,
    input logic          mem_valid,
    input logic          mem_write,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          irq,
    input logic          err
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    // R3
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) && !$past(mem_valid && mem_write)
        |-> $past(mem_valid && !mem_write && mem_ready));

    // R10
    idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ready |-> !mem_valid);

    // R8
    irq_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && err));

    // R2
    fault_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> trig_ready && !mem_valid);

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind dma_link_engine dma_link_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_ready(trig_ready),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .irq(irq), .err(err)
);

// File: tb/sim_dma_link_engine.sv
module sim_dma_link_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_valid = 1'b0;
    logic [6:0]  trig_chan = '0;
    logic        trig_ready;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_chan = '0;
    logic [1:0]  cfg_word = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_valid, mem_write, mem_half;
    logic [27:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ready;
    logic [15:0] mem_rdata;
    logic        irq, err;
    logic [6:0]  evt_chan;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dma_link_engine u0 (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_chan(trig_chan),
        .trig_ready(trig_ready), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_half(mem_half),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .irq(irq), .err(err), .evt_chan(evt_chan)
    );

    // memory model with a varying stall
    logic [1:0] stall, pat;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall <= 2'd1; pat <= 2'd0;
        end else if (mem_valid && mem_ready) begin
            pat   <= (pat == 2'd2) ? 2'd0 : pat + 2'd1;
            stall <= pat;
        end else if (mem_valid && stall != 2'd0) begin
            stall <= stall - 2'd1;
        end
    end
    assign mem_ready = mem_valid && (stall == 2'd0);
    assign mem_rdata = {mem_addr[7:0], ~mem_addr[7:0]};

    // scoreboard: kind 0 read, 1 write, 2 irq, 3 err
    typedef struct packed {
        logic [1:0]  kind;
        logic [27:0] addr;
        logic [15:0] data;
        logic        half;
        logic [7:0]  tag;
    } exp_t;
    exp_t sbq[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic push_unit(input logic [27:0] s, input logic [27:0] d,
                             input logic h, input logic [7:0] tag);
        sbq.push_back({2'd0, s, 16'h0, h, tag});
        sbq.push_back({2'd1, d, {s[7:0], ~s[7:0]}, h, tag});
    endtask

    task automatic push_evt(input logic [1:0] k, input logic [6:0] ch, input logic [7:0] tag);
        sbq.push_back({k, 21'd0, ch, 16'h0, 1'b0, tag});
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_valid && mem_ready) begin
                if (sbq.size() == 0) check(1'b0, "R10 unexpected access", {4'h0, mem_addr}, 32'h0);
                else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(e.kind == {1'b0, mem_write}, $sformatf("R%0d kind", e.tag),
                          {31'd0, mem_write}, {30'd0, e.kind});
                    check(mem_addr == e.addr, $sformatf("R%0d addr", e.tag),
                          {4'h0, mem_addr}, {4'h0, e.addr});
                    check(mem_half == e.half, "R3 size", {31'd0, mem_half}, {31'd0, e.half});
                    if (mem_write)
                        check(mem_wdata == e.data, "R3 data", {16'd0, mem_wdata}, {16'd0, e.data});
                end
            end
            if (irq || err) begin
                if (sbq.size() == 0) check(1'b0, "R8 unexpected event", {24'd0, irq, evt_chan}, 32'h0);
                else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(e.kind == (irq ? 2'd2 : 2'd3), $sformatf("R%0d event kind", e.tag),
                          {30'd0, irq ? 2'd2 : 2'd3}, {30'd0, e.kind});
                    check(evt_chan == e.addr[6:0], $sformatf("R%0d event chan", e.tag),
                          {25'd0, evt_chan}, {25'd0, e.addr[6:0]});
                end
            end
        end
    end

    task automatic put_desc(input logic [6:0] ch, input logic [31:0] a,
                            input logic [31:0] b, input logic [31:0] c);
        logic [31:0] wv [3];
        wv[0] = a; wv[1] = b; wv[2] = c;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_chan = ch; cfg_word = 2'(i); cfg_wdata = wv[i];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_word(input logic [6:0] ch, input logic [1:0] w,
                             input logic [31:0] expv, input string req);
        @(negedge clk);
        cfg_chan = ch; cfg_word = w;
        #1;
        check(cfg_rdata == expv, req, cfg_rdata, expv);
    endtask

    task automatic fire(input logic [6:0] ch);
        @(negedge clk);
        trig_valid = 1'b1; trig_chan = ch;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        @(negedge clk);
        while (!trig_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sbq.size() == 0, req, sbq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(trig_ready && !mem_valid && !irq && !err, "R1 reset",
              {28'd0, trig_ready, mem_valid, irq, err}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R4: successive, byte, src up, dst fixed, 3 units
        put_desc(7'd5, 32'h0000_0003, 32'hB000_1000, 32'h4000_2000);
        for (int i = 0; i < 3; i++) push_unit(28'h1000 + 28'(i), 28'h2000, 1'b0, 8'd5);
        push_evt(2'd2, 7'd5, 8'd8);
        fire(7'd5);
        wait_idle("R5 successive run drained");
        read_word(7'd5, 2'd0, 32'h0000_0000, "R5 count writeback");
        read_word(7'd5, 2'd1, 32'hB000_1003, "R4 src up writeback");
        read_word(7'd5, 2'd2, 32'h4000_2000, "R4 dst fixed writeback");

        // R6 R4: single, half-word, src down, dst up, count 2
        put_desc(7'd7, 32'h0000_0002, 32'hD000_3000, 32'h3000_4000);
        push_unit(28'h3000, 28'h4000, 1'b1, 8'd6);
        fire(7'd7);
        wait_idle("R6 first single trigger, no irq");
        read_word(7'd7, 2'd0, 32'h0000_0001, "R6 count writeback");
        read_word(7'd7, 2'd1, 32'hD000_2FFE, "R4 half-word down step");
        read_word(7'd7, 2'd2, 32'h3000_4002, "R4 half-word up step");
        push_unit(28'h2FFE, 28'h4002, 1'b1, 8'd6);
        push_evt(2'd2, 7'd7, 8'd8);
        fire(7'd7);
        wait_idle("R6 second single trigger completes");
        read_word(7'd7, 2'd0, 32'h0000_0000, "R6 final count");

        // R7 R9: block, src reload, dst continue, 2 blocks of 3, link to 9
        put_desc(7'd9, 32'h0000_0001, 32'h8000_7000, 32'h4000_8000);
        put_desc(7'd10, 32'h8900_0203, 32'h2000_5000, 32'hB000_6000);
        for (int i = 0; i < 3; i++) push_unit(28'h5000 + 28'(i), 28'h6000 + 28'(i), 1'b0, 8'd7);
        fire(7'd10);
        wait_idle("R9 no follow-up before finish");
        read_word(7'd10, 2'd0, 32'h8900_0103, "R7 block count writeback");
        read_word(7'd10, 2'd1, 32'h2000_5000, "R7 src reloaded");
        read_word(7'd10, 2'd2, 32'hB000_6003, "R7 dst continued");
        for (int i = 0; i < 3; i++) push_unit(28'h5000 + 28'(i), 28'h6003 + 28'(i), 1'b0, 8'd7);
        push_unit(28'h7000, 28'h8000, 1'b0, 8'd9);
        push_evt(2'd2, 7'd9, 8'd9);
        fire(7'd10);
        wait_idle("R9 linked channel ran");
        read_word(7'd10, 2'd0, 32'h8900_0003, "R7 last block");
        read_word(7'd10, 2'd2, 32'hB000_6006, "R7 dst after two blocks");
        read_word(7'd9, 2'd0, 32'h0000_0000, "R9 linked count");

        // R2: reserved mode
        put_desc(7'd20, 32'h0000_0004, 32'h8000_0100, 32'hC000_0200);
        push_evt(2'd3, 7'd20, 8'd2);
        fire(7'd20);
        wait_idle("R2 fault, no access");
        read_word(7'd20, 2'd0, 32'h0000_0004, "R2 record unchanged");

        // R5 R10: 256 units from the high count field, busy trigger ignored
        put_desc(7'd30, 32'h0000_0100, 32'h8000_0400, 32'h4000_0500);
        for (int i = 0; i < 256; i++) push_unit(28'h400, 28'h500, 1'b0, 8'd5);
        push_evt(2'd2, 7'd30, 8'd8);
        fire(7'd30);
        repeat (5) @(negedge clk);
        check(!trig_ready, "R10 busy", {31'd0, trig_ready}, 32'd0);
        fire(7'd5);
        wait_idle("R10 busy trigger ignored");
        read_word(7'd30, 2'd0, 32'h0000_0000, "R5 high field count done");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule